// File: doc/BRIEF.md
# Clocked Serial Frame Receiver

This block receives character frames over a two-wire clocked serial link: a shared serial clock and one data line. The serial clock may come from the local master or from a remote device. Both lines are brought into the system clock domain through a short synchronizer. A polarity input selects which serial clock edge takes a sample. The sender changes the data line on the other edge, so each sample is taken while the line is stable.

A low sample on an idle line marks the start of a frame. The block then collects between five and nine data bits, least significant first. If parity is enabled, it reads one parity bit and compares it against the chosen sense, even or odd. It then reads one or two stop bits. When the last stop bit has been sampled, the character is placed on a parallel output along with a parity-error flag and a frame-error flag, and a strobe marks it for one system clock cycle. The length, parity and stop settings are captured when the start bit is seen, so the whole frame uses one consistent format.

Top module: `sync_frame_rx`

## Requirements
- R1: With `cfg_pol` = 0 the data line is sampled on the falling edge of `ser_clk`; with `cfg_pol` = 1 it is sampled on the rising edge. Two successive samples are never taken in adjacent system clock cycles.
- R2: While no frame is in progress, high samples are ignored and produce no strobe. A low sample starts a frame.
- R3: `cfg_len` gives the data length as code 0..4 for 5..9 bits. Codes 5..7 mean 9 bits. Data bits arrive least significant first, and data bit k appears at `rx_data[k]`.
- R4: `rx_data` bits at positions equal to or above the data length are zero.
- R5: With `cfg_par_en` = 1, one parity bit follows the data. Even parity (`cfg_par_odd` = 0) requires the XOR of the data and parity bits to be 0; odd parity requires it to be 1. A mismatch sets `rx_perr` for that character. With parity disabled, `rx_perr` is 0.
- R6: One stop bit follows, or two when `cfg_two_stop` = 1. A low sample in any stop position sets `rx_ferr`. The character completes right after the last stop sample.
- R7: `rx_data`, `rx_perr` and `rx_ferr` change only in a cycle where `rx_valid` is high, and they hold their values until the next completed frame.
- R8: `rx_valid` is high for exactly one system clock cycle per completed frame.
- R9: A start bit sampled right after the last stop bit begins a new frame, with no idle bit required between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, local or external |
| ser_din | input | 1 | Serial data line, idles high |
| cfg_pol | input | 1 | Sample edge select: 0 falling, 1 rising |
| cfg_len | input | 3 | Data length code, 0..4 for 5..9 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_two_stop | input | 1 | Two stop bits when high |
| rx_data | output | 9 | Received character, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| rx_perr | output | 1 | Parity mismatch for the presented character |
| rx_ferr | output | 1 | Low stop bit for the presented character |

## Verification
The hardest case to reach from the ports is a start bit that falls on the sample edge right after a final stop bit, with no idle gap. That case only occurs if the bench, acting as master, drives the serial clock and data together with bit-exact timing. The bench produces each bit as a change edge followed by a sample edge, with the level chosen by polarity. It sends frames back to back and checks that both characters arrive. The sweep covers both polarities, all five lengths, all three parity modes and both stop counts. In every configuration it injects parity and stop errors, and it sends data whose bits above the length are set, so the zero-extension check is meaningful.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int DW = 9;
    localparam int CW = $clog2(DW) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_st_e;

    typedef struct packed {
        rx_st_e          st;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   last;
        logic            par_en;
        logic            par_odd;
        logic            two_stop;
        logic            acc;
        logic            perr_p;
        logic            ferr_p;
        logic [DW-1:0]   shf;
        logic [DW-1:0]   data;
        logic            perr;
        logic            ferr;
        logic            valid;
    } rx_reg_s;
endpackage

// File: rtl/sfr_edge_sync.sv
module sfr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_din,
    input  logic pol,
    output logic samp_pulse,
    output logic samp_bit
);
    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dn;
        logic              prev;
    } sync_s;

    sync_s sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.ck   = {sy_q.ck[STAGES-2:0], ser_clk};
        sy_d.dn   = {sy_q.dn[STAGES-2:0], ser_din};
        sy_d.prev = sy_q.ck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.ck   <= '0;
            sy_q.dn   <= '1;
            sy_q.prev <= 1'b0;
        end else begin
            sy_q <= sy_d;
        end
    end

    logic clk_s, rise, fall;
    assign clk_s      = sy_q.ck[STAGES-1];
    assign rise       = clk_s & ~sy_q.prev;
    assign fall       = ~clk_s & sy_q.prev;
    assign samp_pulse = pol ? rise : fall;
    assign samp_bit   = sy_q.dn[STAGES-1];
endmodule

// File: rtl/sfr_frame_fsm.sv
module sfr_frame_fsm
    import sfr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_pulse,
    input  logic          samp_bit,
    input  logic [2:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_perr,
    output logic          rx_ferr
);
    rx_reg_s r_d, r_q;
    logic    ferr_now;

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        ferr_now = r_q.ferr_p | ~samp_bit;
        if (samp_pulse) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!samp_bit) begin
                        r_d.st       = ST_DATA;
                        r_d.cnt      = '0;
                        r_d.last     = (cfg_len > 3'd4) ? CW'(DW - 1)
                                                        : (CW'(cfg_len) + CW'(4));
                        r_d.par_en   = cfg_par_en;
                        r_d.par_odd  = cfg_par_odd;
                        r_d.two_stop = cfg_two_stop;
                        r_d.acc      = 1'b0;
                        r_d.perr_p   = 1'b0;
                        r_d.ferr_p   = 1'b0;
                        r_d.shf      = '0;
                    end
                end
                ST_DATA: begin
                    r_d.shf[r_q.cnt] = samp_bit;
                    r_d.acc          = r_q.acc ^ samp_bit;
                    r_d.cnt          = r_q.cnt + CW'(1);
                    if (r_q.cnt == r_q.last)
                        r_d.st = r_q.par_en ? ST_PAR : ST_STOP1;
                end
                ST_PAR: begin
                    r_d.perr_p = r_q.acc ^ samp_bit ^ r_q.par_odd;
                    r_d.st     = ST_STOP1;
                end
                ST_STOP1: begin
                    if (r_q.two_stop) begin
                        r_d.ferr_p = ferr_now;
                        r_d.st     = ST_STOP2;
                    end else begin
                        r_d.data  = r_q.shf;
                        r_d.perr  = r_q.perr_p;
                        r_d.ferr  = ferr_now;
                        r_d.valid = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
                ST_STOP2: begin
                    r_d.data  = r_q.shf;
                    r_d.perr  = r_q.perr_p;
                    r_d.ferr  = ferr_now;
                    r_d.valid = 1'b1;
                    r_d.st    = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data  = r_q.data;
    assign rx_valid = r_q.valid;
    assign rx_perr  = r_q.perr;
    assign rx_ferr  = r_q.ferr;
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx
    import sfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_clk,
    input  logic          ser_din,
    input  logic          cfg_pol,
    input  logic [2:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_perr,
    output logic          rx_ferr
);
    logic samp_pulse;
    logic samp_bit;

    sfr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .pol        (cfg_pol),
        .samp_pulse (samp_pulse),
        .samp_bit   (samp_bit)
    );

    sfr_frame_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_pulse   (samp_pulse),
        .samp_bit     (samp_bit),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_odd  (cfg_par_odd),
        .cfg_two_stop (cfg_two_stop),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_perr      (rx_perr),
        .rx_ferr      (rx_ferr)
    );
endmodule

// File: rtl/sfr_rx_checker.sv
module sfr_rx_checker
    import sfr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          samp_pulse,
    input logic [DW-1:0] rx_data,
    input logic          rx_valid,
    input logic          rx_perr,
    input logic          rx_ferr
);
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_sample_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        samp_pulse |=> !samp_pulse);

    assert_output_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rx_data, rx_perr, rx_ferr}) |-> rx_valid);

    assert_done_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(samp_pulse));
endmodule

bind sync_frame_rx sfr_rx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_pulse (samp_pulse),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_perr    (rx_perr),
    .rx_ferr    (rx_ferr)
);

// File: tb/sync_frame_rx_bench.sv
`timescale 1ns/1ps
module sync_frame_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b1;
    logic       cfg_pol = 1'b0;
    logic [2:0] cfg_len = 3'd0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr;

    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    logic [8:0] cap_data, prev_data;
    logic       cap_perr, cap_ferr;

    always #4 clk = ~clk;

    sync_frame_rx u_sync_frame_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .cfg_pol(cfg_pol), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcnt++;
            prev_data = cap_data;
            cap_data  = rx_data;
            cap_perr  = rx_perr;
            cap_ferr  = rx_ferr;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk);
        ser_clk = cfg_pol ? 1'b0 : 1'b1;
        ser_din = b;
        repeat (3) @(negedge clk);
        ser_clk = cfg_pol ? 1'b1 : 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int nb, input bit bad_p,
                        input bit bad_s1, input bit bad_s2, input int idles);
        int m = (1 << nb) - 1;
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(d[i]);
        if (cfg_par_en) bit_out((^(d & 9'(m))) ^ cfg_par_odd ^ bad_p);
        bit_out(!bad_s1);
        if (cfg_two_stop) bit_out(!bad_s2);
        for (int i = 0; i < idles; i++) bit_out(1'b1);
    endtask

    task automatic frame_check(input logic [8:0] d, input int nb, input bit bad_p,
                               input bit bad_s1, input bit bad_s2);
        int v0 = vcnt;
        int m = (1 << nb) - 1;
        logic [8:0] exp_d = d & 9'(m);
        bit exp_p = cfg_par_en && bad_p;
        bit exp_f = bad_s1 || (cfg_two_stop && bad_s2);
        send(d, nb, bad_p, bad_s1, bad_s2, 2);
        repeat (4) @(negedge clk);
        chk(vcnt == v0 + 1, "R8 strobe count", vcnt - v0, 1);
        chk(cap_data == exp_d, "R3 data LSB first", cap_data, exp_d);
        chk((int'(cap_data) >> nb) == 0, "R4 upper zero", cap_data, exp_d);
        chk(cap_perr == exp_p, "R5 parity flag", cap_perr, exp_p);
        chk(cap_ferr == exp_f, "R6 frame flag", cap_ferr, exp_f);
        chk(rx_data == exp_d, "R7 held output", rx_data, exp_d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        logic [8:0] vals [3];
        repeat (5) @(negedge clk);
        chk(rx_valid == 1'b0, "reset valid", rx_valid, 0);
        chk(rx_data == 9'h0, "reset data", rx_data, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int p = 0; p < 2; p++) begin
            cfg_pol = p[0];
            ser_clk = cfg_pol;
            v0 = vcnt;
            for (int i = 0; i < 5; i++) bit_out(1'b1);
            repeat (4) @(negedge clk);
            chk(vcnt == v0, "R2 idle ignored", vcnt - v0, 0);
            for (int l = 0; l < 5; l++) begin
                for (int pm = 0; pm < 3; pm++) begin
                    for (int s = 0; s < 2; s++) begin
                        cfg_len      = 3'(l);
                        cfg_par_en   = (pm != 0);
                        cfg_par_odd  = (pm == 2);
                        cfg_two_stop = s[0];
                        vals[0] = 9'h155 ^ 9'(l * 37 + pm * 11);
                        vals[1] = 9'h0AA ^ 9'(s * 73 + p * 5);
                        vals[2] = 9'h1FF ^ 9'(l * 3);
                        for (int k = 0; k < 3; k++)
                            frame_check(vals[k], l + 5, 1'b0, 1'b0, 1'b0);
                        if (cfg_par_en) frame_check(9'h1E1, l + 5, 1'b1, 1'b0, 1'b0);
                        frame_check(9'h03C, l + 5, 1'b0, 1'b1, 1'b0);
                        if (cfg_two_stop) frame_check(9'h0F0, l + 5, 1'b0, 1'b0, 1'b1);
                    end
                end
            end
            cfg_len = 3'd4; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
            v0 = vcnt;
            send(9'h12D, 9, 1'b0, 1'b0, 1'b0, 0);
            send(9'h0D2, 9, 1'b0, 1'b0, 1'b0, 2);
            repeat (4) @(negedge clk);
            chk(vcnt == v0 + 2, "R9 back-to-back count", vcnt - v0, 2);
            chk(prev_data == 9'h12D, "R9 first char", prev_data, 9'h12D);
            chk(cap_data == 9'h0D2, "R9 second char", cap_data, 9'h0D2);
            chk(cap_perr == 1'b0 && cap_ferr == 1'b0, "R9 flags clean", {cap_perr, cap_ferr}, 0);
        end

        cfg_pol = 1'b0; ser_clk = 1'b0;
        cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        for (int c = 5; c < 8; c++) begin
            cfg_len = 3'(c);
            frame_check(9'h1B7, 9, 1'b0, 1'b0, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule